// File: doc/BRIEF.md
# SDRAM Low-Power State Sequencer

This block sits between a memory controller and a single-data-rate SDRAM. It owns the clock-enable pin and the command slot. Each cycle the controller presents a command on `cmdIn` and may raise one of four requests: enter self refresh, enter power down, suspend the clock during a burst, or leave a low-power state. The sequencer registers CKE and the command one cycle ahead of the device. It admits power down and self refresh only while the controller reports that every bank is idle. Commands from the controller reach the pins unchanged only in the active state.

A clock-enable exit needs time before the device will accept real commands. Self refresh needs `T_RC` cycles and power down needs `T_SS + 1` cycles. During that window a down-counter holds `cmdReady` low and the command slot carries NOP. Any request that breaks an entry or exit rule is dropped and reported by a one-cycle `illegalReq` pulse. The state register is exposed so that the controller can follow the mode.

Top module: `sdram_lp_seq`

## Requirements
- R1: During reset and after it, `stateOut` is 0 (active), `cke` is 1, `cmdOut` is NOP (4'b0111), `cmdReady` is 1 and `illegalReq` is 0. `cmdReady` is 1 exactly while `stateOut` is 0.
- R2: In the active state with no request, `cmdOut` equals the `cmdIn` of the previous cycle and `cke` stays 1. Commands are {csN, rasN, casN, weN}.
- R3: A self-refresh request in the active state while `allBanksIdle` is 1 makes the next cycle show `cke`=0, `cmdOut`=REFRESH (4'b0001) and `stateOut`=2.
- R4: A power-down request in the active state while `allBanksIdle` is 1 makes the next cycle show `cke`=0, `cmdOut`=NOP and `stateOut`=1.
- R5: A power-down or self-refresh request while `allBanksIdle` is 0 raises `illegalReq` for one cycle. The state stays active, `cke` stays 1 and `cmdOut` becomes NOP.
- R6: In power down (1) and self refresh (2), `cke` stays 0 until an exit request. A `cmdIn` other than NOP or deselect (csN=1), or any non-exit request, pulses `illegalReq`, and `cmdOut` is NOP.
- R7: An exit request in self refresh raises `cke` the next cycle and enters state 3. `cmdReady` then stays 0 for exactly `T_RC` cycles.
- R8: An exit request in power down raises `cke` the next cycle and enters state 4. `cmdReady` then stays 0 for exactly `T_SS + 1` cycles.
- R9: During an exit wait (3 or 4), `cmdOut` is NOP. Any `cmdIn` other than NOP or deselect, and any request, pulses `illegalReq`.
- R10: A suspend request in the active state makes the next cycle show `cke`=0, `stateOut`=5 and `cmdOut` equal to the `cmdIn` of the entry cycle. `cmdOut` holds while suspended. Dropping the request gives `cke`=1 and the active state one cycle later.
- R11: REFRESH or MODE SET (4'b0000) on `cmdIn`, either at suspend entry or during suspend, pulses `illegalReq`. A refused entry leaves the state active with `cmdOut` NOP. Power-down, self-refresh and exit requests during suspend also pulse `illegalReq`.
- R12: An exit request in the active state pulses `illegalReq` and outputs NOP.
- R13: Simultaneous requests in the active state are served in the order self refresh, then power down, then suspend, then exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allBanksIdle | input | 1 | Controller reports that every bank is idle |
| reqSelfRefresh | input | 1 | Request to enter self refresh |
| reqPowerDown | input | 1 | Request to enter power down |
| reqSuspend | input | 1 | Held high to suspend the clock |
| reqExit | input | 1 | Request to leave power down or self refresh |
| cmdIn | input | 4 | Controller command {csN, rasN, casN, weN} |
| cke | output | 1 | Registered clock enable to the device |
| cmdOut | output | 4 | Registered command slot to the device |
| cmdReady | output | 1 | Controller may issue real commands |
| illegalReq | output | 1 | One-cycle pulse on a refused request or command |
| stateOut | output | 3 | 0 active, 1 power down, 2 self refresh, 3 self-refresh exit wait, 4 power-down exit wait, 5 suspend |

## Verification
The bench builds the block with `T_RC` = 6 and `T_SS` = 1, so the two exit waits last 6 and 2 cycles. Because the waits differ, swapping the two loads or shortening a count by one shows up directly in the measured length of `cmdReady` low. The short waits let the random run pass through many entry, exit and suspend cycles, including requests that arrive inside a wait and refused entries with busy banks.

// File: rtl/sdram_lp_pkg.sv
package sdram_lp_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE  = 3'd0,
    ST_PWRDN   = 3'd1,
    ST_SELFREF = 3'd2,
    ST_SR_WAIT = 3'd3,
    ST_PD_WAIT = 3'd4,
    ST_SUSPEND = 3'd5
  } lpState_e;

  typedef enum logic [1:0] {
    CS_PASS = 2'd0,
    CS_NOP  = 2'd1,
    CS_REF  = 2'd2,
    CS_HOLD = 2'd3
  } cmdSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    ckeDrop;
    logic    ckeRaise;
    logic    loadSr;
    logic    loadPd;
    logic    countDown;
    cmdSel_e cmdSel;
    logic    flagBad;
  } lpStrobe_t;

  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_MRS = 4'b0000;

  function automatic logic isQuietCmd(input logic [3:0] c);
    return c[3] || (c == CMD_NOP);
  endfunction

  function automatic logic isSuspendBad(input logic [3:0] c);
    return (c == CMD_REF) || (c == CMD_MRS);
  endfunction

endpackage

// File: rtl/sdram_lp_ctrl.sv
module sdram_lp_ctrl
  import sdram_lp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       allBanksIdle,
  input  logic       reqSelfRefresh,
  input  logic       reqPowerDown,
  input  logic       reqSuspend,
  input  logic       reqExit,
  input  logic [3:0] cmdIn,
  input  logic       cntOne,
  output lpStrobe_t  strobe,
  output lpState_e   state
);

  lpState_e nextState;
  logic     anyReq;

  assign anyReq = reqSelfRefresh | reqPowerDown | reqSuspend | reqExit;

  always_comb begin
    strobe        = '0;
    strobe.cmdSel = CS_NOP;
    nextState     = state;
    unique case (state)
      ST_ACTIVE: begin
        if (reqSelfRefresh) begin
          if (allBanksIdle) begin
            nextState      = ST_SELFREF;
            strobe.ckeDrop = 1'b1;
            strobe.cmdSel  = CS_REF;
          end else begin
            strobe.flagBad = 1'b1;
          end
        end else if (reqPowerDown) begin
          if (allBanksIdle) begin
            nextState      = ST_PWRDN;
            strobe.ckeDrop = 1'b1;
          end else begin
            strobe.flagBad = 1'b1;
          end
        end else if (reqSuspend) begin
          if (isSuspendBad(cmdIn)) begin
            strobe.flagBad = 1'b1;
          end else begin
            nextState      = ST_SUSPEND;
            strobe.ckeDrop = 1'b1;
            strobe.cmdSel  = CS_PASS;
          end
        end else if (reqExit) begin
          strobe.flagBad = 1'b1;
        end else begin
          strobe.cmdSel = CS_PASS;
        end
      end
      ST_PWRDN, ST_SELFREF: begin
        strobe.flagBad = !isQuietCmd(cmdIn) | reqSelfRefresh | reqPowerDown | reqSuspend;
        if (reqExit) begin
          strobe.ckeRaise = 1'b1;
          if (state == ST_PWRDN) begin
            nextState     = ST_PD_WAIT;
            strobe.loadPd = 1'b1;
          end else begin
            nextState     = ST_SR_WAIT;
            strobe.loadSr = 1'b1;
          end
        end
      end
      ST_SR_WAIT, ST_PD_WAIT: begin
        strobe.flagBad   = !isQuietCmd(cmdIn) | anyReq;
        strobe.countDown = 1'b1;
        if (cntOne) nextState = ST_ACTIVE;
      end
      ST_SUSPEND: begin
        strobe.cmdSel  = CS_HOLD;
        strobe.flagBad = reqSelfRefresh | reqPowerDown | reqExit | isSuspendBad(cmdIn);
        if (!reqSuspend) begin
          nextState       = ST_ACTIVE;
          strobe.ckeRaise = 1'b1;
        end
      end
      default: nextState = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_ACTIVE;
    else       state <= nextState;
  end

endmodule

// File: rtl/sdram_lp_dp.sv
module sdram_lp_dp
  import sdram_lp_pkg::*;
#(
  parameter int T_RC = 8,
  parameter int T_SS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  lpStrobe_t  strobe,
  input  logic [3:0] cmdIn,
  output logic       cke,
  output logic [3:0] cmdOut,
  output logic       illegalReq,
  output logic       cntOne
);

  localparam int PD_WAIT  = T_SS + 1;
  localparam int MAX_WAIT = (T_RC > PD_WAIT) ? T_RC : PD_WAIT;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  logic [CNT_W-1:0] waitCnt;

  assign cntOne = (waitCnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cke        <= 1'b1;
      cmdOut     <= CMD_NOP;
      illegalReq <= 1'b0;
      waitCnt    <= '0;
    end else begin
      illegalReq <= strobe.flagBad;
      if (strobe.ckeDrop)       cke <= 1'b0;
      else if (strobe.ckeRaise) cke <= 1'b1;
      unique case (strobe.cmdSel)
        CS_PASS: cmdOut <= cmdIn;
        CS_NOP:  cmdOut <= CMD_NOP;
        CS_REF:  cmdOut <= CMD_REF;
        CS_HOLD: cmdOut <= cmdOut;
        default: cmdOut <= CMD_NOP;
      endcase
      if (strobe.loadSr)                          waitCnt <= CNT_W'(T_RC);
      else if (strobe.loadPd)                     waitCnt <= CNT_W'(PD_WAIT);
      else if (strobe.countDown && waitCnt != '0) waitCnt <= waitCnt - 1'b1;
    end
  end

endmodule

// File: rtl/sdram_lp_seq.sv
module sdram_lp_seq
  import sdram_lp_pkg::*;
#(
  parameter int T_RC = 8,
  parameter int T_SS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       allBanksIdle,
  input  logic       reqSelfRefresh,
  input  logic       reqPowerDown,
  input  logic       reqSuspend,
  input  logic       reqExit,
  input  logic [3:0] cmdIn,
  output logic       cke,
  output logic [3:0] cmdOut,
  output logic       cmdReady,
  output logic       illegalReq,
  output logic [2:0] stateOut
);

  lpStrobe_t strobe;
  lpState_e  state;
  logic      cntOne;

  sdram_lp_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .allBanksIdle  (allBanksIdle),
    .reqSelfRefresh(reqSelfRefresh),
    .reqPowerDown  (reqPowerDown),
    .reqSuspend    (reqSuspend),
    .reqExit       (reqExit),
    .cmdIn         (cmdIn),
    .cntOne        (cntOne),
    .strobe        (strobe),
    .state         (state)
  );

  sdram_lp_dp #(.T_RC(T_RC), .T_SS(T_SS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cmdIn     (cmdIn),
    .cke       (cke),
    .cmdOut    (cmdOut),
    .illegalReq(illegalReq),
    .cntOne    (cntOne)
  );

  assign stateOut = state;
  assign cmdReady = (state == ST_ACTIVE);

endmodule

// File: rtl/sdram_lp_chk.sv
module sdram_lp_chk
  import sdram_lp_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       allBanksIdle,
  input logic       reqSelfRefresh,
  input logic       reqPowerDown,
  input logic       reqExit,
  input logic       cke,
  input logic [3:0] cmdOut,
  input logic       cmdReady,
  input logic       illegalReq,
  input logic [2:0] stateOut
);

  a_r1_ready_needs_cke: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> cke);

  a_r3_sr_entry: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == ST_ACTIVE && reqSelfRefresh && allBanksIdle)
      |=> (stateOut == ST_SELFREF && !cke && cmdOut == CMD_REF));

  a_r5_busy_refused: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == ST_ACTIVE && (reqSelfRefresh || reqPowerDown) && !allBanksIdle)
      |=> (stateOut == ST_ACTIVE && cke && illegalReq));

  a_r6_cke_low: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == ST_PWRDN || stateOut == ST_SELFREF) |-> !cke);

  a_r7_sr_exit: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == ST_SELFREF && reqExit) |=> (cke && !cmdReady && stateOut == ST_SR_WAIT));

  a_r8_pd_exit: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == ST_PWRDN && reqExit) |=> (cke && !cmdReady && stateOut == ST_PD_WAIT));

  a_r9_wait_nop: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == ST_SR_WAIT || stateOut == ST_PD_WAIT) |-> (cmdOut == CMD_NOP && !cmdReady));

  a_r10_suspend_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == ST_SUSPEND && $past(stateOut) == ST_SUSPEND) |-> ($stable(cmdOut) && !cke));

endmodule

bind sdram_lp_seq sdram_lp_chk u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .allBanksIdle  (allBanksIdle),
  .reqSelfRefresh(reqSelfRefresh),
  .reqPowerDown  (reqPowerDown),
  .reqExit       (reqExit),
  .cke           (cke),
  .cmdOut        (cmdOut),
  .cmdReady      (cmdReady),
  .illegalReq    (illegalReq),
  .stateOut      (stateOut)
);

// File: tb/sdram_lp_seq_test.sv
module sdram_lp_seq_test;

  localparam int TB_RC = 6;
  localparam int TB_SS = 1;
  localparam logic [3:0] NOP = 4'b0111;
  localparam logic [3:0] REF = 4'b0001;
  localparam logic [3:0] MRS = 4'b0000;
  localparam logic [3:0] RD  = 4'b0101;
  localparam logic [3:0] WR  = 4'b0100;
  localparam logic [3:0] ACT = 4'b0011;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic allBanksIdle = 1'b0, reqSelfRefresh = 1'b0, reqPowerDown = 1'b0;
  logic reqSuspend = 1'b0, reqExit = 1'b0;
  logic [3:0] cmdIn = NOP;
  logic cke, cmdReady, illegalReq;
  logic [3:0] cmdOut;
  logic [2:0] stateOut;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // bench reference state
  logic [2:0] mState = 3'd0;
  logic       mCke = 1'b1;
  logic [3:0] mCmd = NOP;
  logic       mIll = 1'b0;
  int         mCnt = 0;

  always #2 clk = ~clk;

  sdram_lp_seq #(.T_RC(TB_RC), .T_SS(TB_SS)) uut (
    .clk(clk), .rstN(rstN), .allBanksIdle(allBanksIdle),
    .reqSelfRefresh(reqSelfRefresh), .reqPowerDown(reqPowerDown),
    .reqSuspend(reqSuspend), .reqExit(reqExit), .cmdIn(cmdIn),
    .cke(cke), .cmdOut(cmdOut), .cmdReady(cmdReady),
    .illegalReq(illegalReq), .stateOut(stateOut)
  );

  function automatic logic quiet(input logic [3:0] c);
    return c[3] || (c == NOP);
  endfunction

  function automatic logic suspBad(input logic [3:0] c);
    return (c == REF) || (c == MRS);
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll(input string tag);
    check(tag, "state", stateOut, mState);
    check(tag, "cke", cke, mCke);
    check(tag, "cmdOut", cmdOut, mCmd);
    check(tag, "illegalReq", illegalReq, mIll);
    check(tag, "cmdReady", cmdReady, (mState == 3'd0));
  endtask

  task automatic runCycle(input logic sr, input logic pd, input logic su, input logic ex,
                          input logic idle, input logic [3:0] c, input string tag);
    logic [2:0] nS;
    logic nK, nI;
    logic [3:0] nC;
    int nCnt;
    @(negedge clk);
    reqSelfRefresh = sr; reqPowerDown = pd; reqSuspend = su; reqExit = ex;
    allBanksIdle = idle; cmdIn = c;
    nS = mState; nK = mCke; nC = mCmd; nI = 1'b0; nCnt = mCnt;
    case (mState)
      3'd0: begin
        if (sr) begin
          if (idle) begin nS = 3'd2; nK = 1'b0; nC = REF; end
          else begin nI = 1'b1; nC = NOP; end
        end else if (pd) begin
          if (idle) begin nS = 3'd1; nK = 1'b0; nC = NOP; end
          else begin nI = 1'b1; nC = NOP; end
        end else if (su) begin
          if (suspBad(c)) begin nI = 1'b1; nC = NOP; end
          else begin nS = 3'd5; nK = 1'b0; nC = c; end
        end else if (ex) begin
          nI = 1'b1; nC = NOP;
        end else nC = c;
      end
      3'd1, 3'd2: begin
        nC = NOP;
        nI = !quiet(c) || sr || pd || su;
        if (ex) begin
          nK = 1'b1;
          nS = (mState == 3'd1) ? 3'd4 : 3'd3;
          nCnt = (mState == 3'd1) ? TB_SS + 1 : TB_RC;
        end
      end
      3'd3, 3'd4: begin
        nC = NOP;
        nI = !quiet(c) || sr || pd || su || ex;
        nCnt = mCnt - 1;
        if (mCnt == 1) nS = 3'd0;
      end
      default: begin
        nI = sr || pd || ex || suspBad(c);
        if (!su) begin nS = 3'd0; nK = 1'b1; end
      end
    endcase
    @(posedge clk);
    #1;
    mState = nS; mCke = nK; mCmd = nC; mIll = nI; mCnt = nCnt;
    compareAll(tag);
  endtask

  task automatic idleCycle(input string tag);
    runCycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, NOP, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int k;
    void'($urandom(32'd20240611));
    // R1 reset state while held in reset
    repeat (2) @(posedge clk);
    #1;
    compareAll("R1");
    @(negedge clk);
    rstN = 1'b1;
    idleCycle("R1");

    // R2 pass-through of several commands
    runCycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, RD, "R2");
    runCycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, ACT, "R2");
    runCycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b1010, "R2");

    // R5 refused entries with busy banks
    runCycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, NOP, "R5");
    runCycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, RD, "R5");
    idleCycle("R5");

    // R12 exit while active
    runCycle(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, NOP, "R12");
    idleCycle("R12");

    // R13 priority plus R3 entry
    runCycle(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, NOP, "R3");
    check("R13", "state after combined request", stateOut, 2);
    // R6 held low, bad command and bad request flagged
    idleCycle("R6");
    runCycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, ACT, "R6");
    runCycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, NOP, "R6");
    runCycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b1001, "R6");
    // R7 exit and wait length; R9 bad command inside the wait
    runCycle(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, NOP, "R7");
    k = 1;
    runCycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, RD, "R9");
    if (!cmdReady) k++;
    while (!cmdReady && k < 50) begin
      idleCycle("R7");
      if (!cmdReady) k++;
    end
    check("R7", "ready-low cycles", k, TB_RC);

    // R13 power down beats suspend; R4 entry
    runCycle(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, WR, "R4");
    check("R13", "state after pd+suspend", stateOut, 1);
    idleCycle("R6");
    // R8 exit and wait length
    runCycle(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, NOP, "R8");
    k = 1;
    while (!cmdReady && k < 50) begin
      runCycle(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, NOP, "R9");
      if (!cmdReady) k++;
    end
    check("R8", "ready-low cycles", k, TB_SS + 1);

    // R10 suspend with a write in flight
    runCycle(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, WR, "R10");
    runCycle(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, RD, "R10");
    runCycle(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, REF, "R11");
    runCycle(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, NOP, "R11");
    runCycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, NOP, "R10");
    idleCycle("R10");
    // R11 suspend entry refused with MODE SET
    runCycle(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, MRS, "R11");
    idleCycle("R11");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic sr, pd, su, ex, idl;
      logic [3:0] c;
      int r;
      r = $urandom % 20;
      sr = (r == 0); pd = (r == 1); ex = (r == 2) || (r == 3 && mState != 3'd0);
      if (mState == 3'd5) su = ($urandom % 8) != 0;
      else su = (r == 4);
      idl = ($urandom % 4) != 0;
      c = (($urandom % 3) == 0) ? 4'($urandom) : NOP;
      runCycle(sr, pd, su, ex, idl, c, "R2");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule